// File: doc/BRIEF.md
# Word Clock Pulse Shaper

This block drives the parallel word clock of a receiving serial link. It runs on the recovered serial bit clock. Each time the deserializer reports a word boundary, the block starts one word-clock cycle. That cycle has an active phase whose length is a programmable number of bit periods, followed by a rest phase that lasts until the next boundary. A two-bit width code selects the active length: 7, 13 or 17 bit periods. One of the 7-bit codes inverts the polarity, so the sink reads data on the falling edge. This gives RGB sinks a duty cycle near 50%.

The width code is sampled only on the bit-clock edge that accepts a boundary. A code change in the middle of a word therefore never produces a runt pulse. The block also has a direction flag. When that flag selects serializer operation, the width pins serve another purpose, so the block ignores them and its output enable is low. While the power-down flag is high, the output enable is low, which models the high-impedance state. Power-down also clears all internal state.

No data stream passes through this block, so it has no valid/ready handshake and no back-pressure. All pins are plain control and clock levels.

Top module: `wclk_shaper`

## Requirements
- R1: A boundary (`word_bnd` high at a rising `bit_clk` edge while `deser_en`=1 and `pwr_dn`=0) starts the active phase from that edge onward.
- R2: Width code `pw_sel`=2'b00 makes `wclk_o` low for 7 bit periods after the boundary edge, then high until the next boundary.
- R3: Width code 2'b01 makes `wclk_o` high for 7 bit periods after the boundary edge, then low until the next boundary (inverted polarity, falling read edge).
- R4: Width code 2'b10 makes `wclk_o` low for 13 bit periods, and code 2'b11 makes it low for 17 bit periods, each followed by high.
- R5: A boundary that arrives during an active phase restarts the timing with the code sampled at the new boundary. The earlier phase is not extended.
- R6: A change of `pw_sel` without a boundary changes neither the current phase length nor the polarity that follows it.
- R7: While `pwr_dn`=1, `wclk_oe` is 0 and boundaries are ignored. Power-down clears any phase in progress, so `wclk_o` is high with no pending pulse once `pwr_dn` falls.
- R8: While `deser_en`=0 (serializer direction), `wclk_oe` is 0, boundaries and width codes are ignored, and `wclk_o` rests high.
- R9: After reset, `wclk_o` is high and no active phase is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; one period is one bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_bnd | input | 1 | One-cycle word-boundary pulse from the deserializer |
| pw_sel | input | 2 | Width/polarity code, sampled at a boundary |
| pwr_dn | input | 1 | Power-down flag; clears state and disables the output |
| deser_en | input | 1 | Direction flag: 1 = deserializer, 0 = serializer |
| wclk_o | output | 1 | Word clock level |
| wclk_oe | output | 1 | Output enable for the word clock (0 = high impedance) |

## Verification
On every cycle, the checker ensures the following. The output enable is off in power-down and in serializer direction. An accepted boundary starts an active phase of the right polarity. An active phase never begins without a boundary. No single phase runs longer than the longest code. Only the bench's scenarios can show the exact phase lengths of each code, the restart on an early boundary, and the rest level held after an inverted word. They also show that a mid-word code change has no effect, and that state left over from power-down or serializer direction has been cleared.

// File: rtl/wcs_pkg.sv
`timescale 1ns/1ps
package wcs_pkg;
  // Width/polarity codes; values match the pw_sel pin encoding.
  typedef enum logic [1:0] {
    PW_SHORT_RISE = 2'b00,
    PW_SHORT_FALL = 2'b01,
    PW_MID_RISE   = 2'b10,
    PW_LONG_RISE  = 2'b11
  } pw_code_e;
endpackage

// File: rtl/wcs_decode.sv
`timescale 1ns/1ps
module wcs_decode #(
  parameter int LOW_SHORT = 7,
  parameter int LOW_MID   = 13,
  parameter int LOW_LONG  = 17,
  parameter int CNT_W     = 5
) (
  input  logic [1:0]       pw_sel,
  output logic [CNT_W-1:0] load_len,
  output logic             invert
);
  import wcs_pkg::*;

  pw_code_e code;
  assign code = pw_code_e'(pw_sel);

  always_comb begin
    load_len = CNT_W'(LOW_SHORT);
    invert   = 1'b0;
    unique case (code)
      PW_SHORT_RISE: load_len = CNT_W'(LOW_SHORT);
      PW_SHORT_FALL: begin
        load_len = CNT_W'(LOW_SHORT);
        invert   = 1'b1;
      end
      PW_MID_RISE:   load_len = CNT_W'(LOW_MID);
      PW_LONG_RISE:  load_len = CNT_W'(LOW_LONG);
      default:       load_len = CNT_W'(LOW_SHORT);
    endcase
  end
endmodule

// File: rtl/wcs_low_timer.sv
`timescale 1ns/1ps
module wcs_low_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             active
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   remain_q <= '0;
    else if (clr)                 remain_q <= '0;
    else if (load)                remain_q <= load_len;
    else if (remain_q != '0)      remain_q <= remain_q - CNT_W'(1);
  end

  assign active = (remain_q != '0);
endmodule

// File: rtl/wcs_out_stage.sv
`timescale 1ns/1ps
module wcs_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic invert_in,
  input  logic active,
  input  logic enable,
  output logic wclk,
  output logic oe
);
  logic inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     inv_q <= 1'b0;
    else if (clr)   inv_q <= 1'b0;
    else if (load)  inv_q <= invert_in;
  end

  // Non-inverted: active phase low, rest high. Inverted: the opposite.
  assign wclk = inv_q ? active : ~active;
  assign oe   = enable;
endmodule

// File: rtl/wclk_shaper.sv
`timescale 1ns/1ps
module wclk_shaper #(
  parameter int LOW_SHORT = 7,
  parameter int LOW_MID   = 13,
  parameter int LOW_LONG  = 17
) (
  input  logic       bit_clk,
  input  logic       rst_n,
  input  logic       word_bnd,
  input  logic [1:0] pw_sel,
  input  logic       pwr_dn,
  input  logic       deser_en,
  output logic       wclk_o,
  output logic       wclk_oe
);
  localparam int CNT_W = $clog2(LOW_LONG + 1);

  logic             enable;
  logic             clr;
  logic             load;
  logic [CNT_W-1:0] load_len;
  logic             invert;
  logic             active;

  assign enable = deser_en & ~pwr_dn;
  assign clr    = ~enable;
  assign load   = word_bnd & enable;

  wcs_decode #(
    .LOW_SHORT(LOW_SHORT), .LOW_MID(LOW_MID), .LOW_LONG(LOW_LONG), .CNT_W(CNT_W)
  ) u_decode (
    .pw_sel  (pw_sel),
    .load_len(load_len),
    .invert  (invert)
  );

  wcs_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load    (load),
    .load_len(load_len),
    .active  (active)
  );

  wcs_out_stage u_out (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (load),
    .invert_in(invert),
    .active   (active),
    .enable   (enable),
    .wclk     (wclk_o),
    .oe       (wclk_oe)
  );
endmodule

// File: rtl/wclk_shaper_chk.sv
`timescale 1ns/1ps
module wclk_shaper_chk #(
  parameter int LOW_LONG = 17
) (
  input logic       bit_clk,
  input logic       rst_n,
  input logic       word_bnd,
  input logic [1:0] pw_sel,
  input logic       pwr_dn,
  input logic       deser_en,
  input logic       wclk_o,
  input logic       wclk_oe,
  input logic       active
);
  localparam int RUN_W = $clog2(LOW_LONG + 2) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (word_bnd) run_q <= '0;
    else if (active)   run_q <= run_q + RUN_W'(1);
    else               run_q <= '0;
  end

  p_hiz_pd_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pwr_dn |-> !wclk_oe);
  p_pd_clear_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pwr_dn |=> (wclk_o && !active));
  p_hiz_ser_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !deser_en |-> !wclk_oe);
  p_ser_idle_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !deser_en |=> wclk_o);
  p_start_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (word_bnd && deser_en && !pwr_dn) |=> active);
  p_start_low_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (word_bnd && deser_en && !pwr_dn && pw_sel != 2'b01) |=> !wclk_o);
  p_start_high_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (word_bnd && deser_en && !pwr_dn && pw_sel == 2'b01) |=> wclk_o);
  p_no_runt_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!word_bnd && !active) |=> !active);
  p_len_max_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    run_q <= RUN_W'(LOW_LONG));
endmodule

bind wclk_shaper wclk_shaper_chk #(.LOW_LONG(LOW_LONG)) u_chk (
  .bit_clk (bit_clk),
  .rst_n   (rst_n),
  .word_bnd(word_bnd),
  .pw_sel  (pw_sel),
  .pwr_dn  (pwr_dn),
  .deser_en(deser_en),
  .wclk_o  (wclk_o),
  .wclk_oe (wclk_oe),
  .active  (active)
);

// File: tb/tb_wclk_shaper.sv
`timescale 1ns/1ps
module tb_wclk_shaper;
  logic       bit_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       word_bnd = 1'b0;
  logic [1:0] pw_sel   = 2'b00;
  logic       pwr_dn   = 1'b0;
  logic       deser_en = 1'b1;
  logic       wclk_o;
  logic       wclk_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 bit_clk = ~bit_clk;

  wclk_shaper dut (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .word_bnd(word_bnd),
    .pw_sel  (pw_sel),
    .pwr_dn  (pwr_dn),
    .deser_en(deser_en),
    .wclk_o  (wclk_o),
    .wclk_oe (wclk_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a boundary for exactly one rising edge; returns just after that edge.
  task automatic boundary(input logic [1:0] code);
    @(negedge bit_clk);
    word_bnd = 1'b1;
    pw_sel   = code;
    @(posedge bit_clk);
    #1 word_bnd = 1'b0;
  endtask

  // Count consecutive falling-edge samples at level lvl.
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge bit_clk);
      if (wclk_o == lvl) n++;
      else break;
    end
  endtask

  task automatic hold_level(input logic lvl, input int cycles, input string req);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge bit_clk);
      if (wclk_o != lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge bit_clk);
    check(wclk_o == 1'b1, "R9 reset level", wclk_o, 1);
    check(wclk_oe == 1'b1, "R9 enable after reset", wclk_oe, 1);
    hold_level(1'b1, 5, "R9 no pending pulse");
  endtask

  task automatic t_code(input logic [1:0] code, input logic act_lvl, input int exp, input string req);
    int n;
    boundary(code);
    run_len(act_lvl, n);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_inverted_rest();
    int n;
    boundary(2'b01);
    run_len(1'b1, n);
    check(n == 7, "R3 inverted active length", n, 7);
    hold_level(1'b0, 10, "R3 inverted rest level low");
    boundary(2'b00);
    run_len(1'b0, n);
    check(n == 7, "R2 normal after inverted", n, 7);
    hold_level(1'b1, 5, "R2 rest level high");
  endtask

  task automatic t_early_boundary();
    int n;
    boundary(2'b11);
    for (int i = 0; i < 5; i++) @(negedge bit_clk);
    check(wclk_o == 1'b0, "R5 still active before restart", wclk_o, 0);
    // boundary task waits one more negedge; total active before restart edge = 6 samples
    boundary(2'b00);
    run_len(1'b0, n);
    check(n == 7, "R5 restart uses new code length", n, 7);
  endtask

  task automatic t_sel_change();
    int n;
    boundary(2'b00);
    @(negedge bit_clk);
    pw_sel = 2'b11;
    @(negedge bit_clk);
    pw_sel = 2'b01;
    run_len(1'b0, n);
    check(n == 5, "R6 length unchanged by mid-word code", n, 5);
    hold_level(1'b1, 10, "R6 polarity unchanged by mid-word code");
    pw_sel = 2'b00;
  endtask

  task automatic t_power_down();
    boundary(2'b11);
    @(negedge bit_clk);
    pwr_dn = 1'b1;
    #0.5;
    check(wclk_oe == 1'b0, "R7 enable off in power-down", wclk_oe, 0);
    boundary(2'b01);
    @(negedge bit_clk);
    check(wclk_oe == 1'b0, "R7 enable stays off", wclk_oe, 0);
    pwr_dn = 1'b0;
    #0.5;
    check(wclk_oe == 1'b1, "R7 enable back on", wclk_oe, 1);
    hold_level(1'b1, 25, "R7 phase cleared and boundary ignored");
  endtask

  task automatic t_serializer();
    boundary(2'b10);
    @(negedge bit_clk);
    deser_en = 1'b0;
    #0.5;
    check(wclk_oe == 1'b0, "R8 enable off in serializer", wclk_oe, 0);
    boundary(2'b01);
    hold_level(1'b1, 20, "R8 boundaries ignored, rest high");
    @(negedge bit_clk);
    deser_en = 1'b1;
    #0.5;
    check(wclk_oe == 1'b1, "R8 enable back on", wclk_oe, 1);
    hold_level(1'b1, 20, "R8 no pulse after return");
  endtask

  task automatic t_back_to_back();
    int n;
    boundary(2'b10);
    run_len(1'b0, n);
    check(n == 13, "R1 first word length", n, 13);
    boundary(2'b10);
    run_len(1'b0, n);
    check(n == 13, "R1 second word length", n, 13);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bit_clk);
    rst_n = 1'b1;
    t_reset();
    t_code(2'b00, 1'b0, 7,  "R2 code 00 low length");
    hold_level(1'b1, 5, "R2 rest high");
    t_code(2'b10, 1'b0, 13, "R4 code 10 low length");
    t_code(2'b11, 1'b0, 17, "R4 code 11 low length");
    t_inverted_rest();
    t_early_boundary();
    t_sel_change();
    t_power_down();
    t_serializer();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule